// File: doc/BRIEF.md
# Scaled-Counter Four-Channel PWM Timer

This block is a PWM timer placed on a simple word-addressed register port. One wide free-running counter is shared by four compare channels. A 4-bit scale value selects which window of the counter feeds the comparators. The window is the counter shifted right by the scale and cut to the comparator width. Each step of scale therefore doubles the period, and the period can only be set in powers of two.

Each channel drives one output that is active low. The output is held low while the scaled count is below that channel's compare value and is high for the rest of the period. The top scaled step always leaves the output high, so a full 100% active time is not possible.

Counting runs while either the continuous-run bit or the single-period bit of the configuration word is set. In zero-compare mode, channel 0's compare value sets where the period ends. Compare values apply on the next clock, so a write made in mid-period can give one period that mixes the old and new settings. Software reads all state back through a registered read port.

Top module: `pwm_scaled_timer`

## Requirements
- R1: Reset clears the configuration word, the counter and every compare value. All outputs sit high and `rdData` reads 0.
- R2: The configuration word is at word address 0. Its writable bits are scale [3:0], hold-mode 8, zero-compare 9, filter 10, run-continuous 12, run-once 13, centre 16, pairing 24 and pending-flag 28, which gives the mask 0x1101370F. All other bits read 0. Bits 8, 10, 16, 24 and 28 only read back.
- R3: The counter advances by one each clock while bit 12 or bit 13 is set, and otherwise holds its value. Its raw value reads at word address 2.
- R4: The scaled count is the counter shifted right by the scale and truncated to CMP_W bits. It reads at word address 4.
- R5: While counting, output i is low when the scaled count is below compare value i, and is high otherwise. A compare value of 0 keeps the output high all the time. When the scaled count is at its maximum, every output is high.
- R6: When bits 12 and 13 are both clear, every output is high.
- R7: With zero-compare clear, one period lasts 2^(CMP_W+scale) clocks.
- R8: With zero-compare set, the counter returns to 0 after the last clock of the step in which the scaled count equals compare value 0. The period is then (cmp0+1)·2^scale clocks.
- R9: Run-once (bit 13) clears itself at the end of a period. With zero-compare clear the counter then stops at the next multiple of 2^(CMP_W+scale).
- R10: A compare write, at word address 8+i, takes effect on the output at the next clock edge and does not wait for a period boundary.
- R11: `rdData` is loaded on the clock edge that samples `rdEn` and holds while `rdEn` is low. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Single-cycle write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Registered read data |
| pwmOut | output | NUM_CH | Active-low channel outputs |

## Verification
The bench builds the block with CMP_W=4 and CNT_W=19, which makes a scale-0 period 16 clocks long. With periods this short, the bench can measure exact period lengths, count low cycles across whole periods, observe zero-compare wrap and run-once termination, and test scaled-count truncation within a few hundred cycles. The register map and the four channels keep their default layout.

// File: rtl/pwm_scaled_timer_pkg.sv
package pwm_scaled_timer_pkg;

  // word addresses
  localparam int ADDR_CFG      = 0;
  localparam int ADDR_COUNT    = 2;
  localparam int ADDR_SCALED   = 4;
  localparam int ADDR_CMP_BASE = 8;

  // configuration bit positions (decoded by the datapath)
  localparam int BIT_ZERO_CMP = 9;
  localparam int BIT_RUN_CONT = 12;
  localparam int BIT_RUN_ONCE = 13;
  localparam logic [31:0] CFG_MASK = 32'h1101_370F;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CFG,
    RD_COUNT,
    RD_SCALED,
    RD_CMP
  } rdSel_e;

  typedef struct packed {
    logic       cfgWr;
    logic       cmpWr;
    logic [2:0] chSel;
    logic       rdEn;
    rdSel_e     rdSel;
  } ctrlStrb_t;

endpackage

// File: rtl/pwm_scaled_timer_ctrl.sv
module pwm_scaled_timer_ctrl
  import pwm_scaled_timer_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 4
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrb_t         strb
);

  logic [31:0] addrW;
  logic        inCmp;

  assign addrW = {{(32 - ADDR_W){1'b0}}, addr};
  assign inCmp = (addrW >= 32'(ADDR_CMP_BASE)) && (addrW < 32'(ADDR_CMP_BASE + NUM_CH));

  always_comb begin
    strb       = '0;
    strb.rdEn  = rdEn;
    strb.rdSel = RD_NONE;
    strb.chSel = inCmp ? 3'(addrW - 32'(ADDR_CMP_BASE)) : 3'd0;
    strb.cfgWr = wrEn && (addrW == 32'(ADDR_CFG));
    strb.cmpWr = wrEn && inCmp;
    if (addrW == 32'(ADDR_CFG))         strb.rdSel = RD_CFG;
    else if (addrW == 32'(ADDR_COUNT))  strb.rdSel = RD_COUNT;
    else if (addrW == 32'(ADDR_SCALED)) strb.rdSel = RD_SCALED;
    else if (inCmp)                     strb.rdSel = RD_CMP;
  end

endmodule

// File: rtl/pwm_scaled_timer_dp.sv
module pwm_scaled_timer_dp
  import pwm_scaled_timer_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CMP_W   = 16,
  parameter int CNT_W   = 31,
  parameter int SCALE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] pwmOut
);

  localparam int MAX_SCALE = (1 << SCALE_W) - 1;

  initial begin
    if (CNT_W < CMP_W + MAX_SCALE || CNT_W > 32 || NUM_CH > 8)
      $error("pwm_scaled_timer_dp: unsupported parameter set");
  end

  logic [31:0]        cfgQ;
  logic [CNT_W-1:0]   countQ;
  logic [CMP_W-1:0]   cmpQ [NUM_CH];
  logic [SCALE_W-1:0] scale;
  logic               zeroCmp, running, stepEnd, periodEnd;
  logic [CNT_W-1:0]   lowMask, cntShift;
  logic [CMP_W-1:0]   scaled, cmpRd;

  assign scale    = cfgQ[SCALE_W-1:0];
  assign zeroCmp  = cfgQ[BIT_ZERO_CMP];
  assign running  = cfgQ[BIT_RUN_CONT] | cfgQ[BIT_RUN_ONCE];
  assign lowMask  = (CNT_W'(1) << scale) - CNT_W'(1);
  assign cntShift = countQ >> scale;
  assign scaled   = cntShift[CMP_W-1:0];
  assign stepEnd  = (countQ & lowMask) == lowMask;
  assign periodEnd = stepEnd && (zeroCmp ? (scaled == cmpQ[0]) : (&scaled));

  // configuration word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (strb.cfgWr) cfgQ <= wrData & CFG_MASK;
    else if (running && periodEnd) cfgQ[BIT_RUN_ONCE] <= 1'b0;
  end

  // shared counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countQ <= '0;
    else if (running) countQ <= (zeroCmp && periodEnd) ? '0 : countQ + CNT_W'(1);
  end

  // per-channel compare registers and outputs
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cmpQ[i] <= '0;
      else if (strb.cmpWr && (int'(strb.chSel) == i)) cmpQ[i] <= wrData[CMP_W-1:0];
    end
    assign pwmOut[i] = ~(running && (scaled < cmpQ[i]));

    // zero compare gives no active time
    p_zero_cmp_high_r5: assert property (@(posedge clk) disable iff (!rstN)
      (cmpQ[i] == '0) |-> pwmOut[i]);
  end

  always_comb begin
    cmpRd = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (int'(strb.chSel) == i) cmpRd = cmpQ[i];
  end

  // registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strb.rdEn) begin
      unique case (strb.rdSel)
        RD_CFG:    rdData <= cfgQ;
        RD_COUNT:  rdData <= 32'(countQ);
        RD_SCALED: rdData <= 32'(scaled);
        RD_CMP:    rdData <= 32'(cmpRd);
        default:   rdData <= '0;
      endcase
    end
  end

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> $stable(countQ));
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (&pwmOut));
  p_top_step_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (&scaled) |-> (&pwmOut));
  p_zero_cmp_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (running && zeroCmp && periodEnd) |=> (countQ == '0));
  p_once_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgQ[BIT_RUN_ONCE] && periodEnd && !strb.cfgWr) |=> !cfgQ[BIT_RUN_ONCE]);
  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> $stable(rdData));

endmodule

// File: rtl/pwm_scaled_timer.sv
module pwm_scaled_timer
  import pwm_scaled_timer_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CMP_W   = 16,
  parameter int CNT_W   = 31,
  parameter int SCALE_W = 4,
  parameter int ADDR_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] pwmOut
);

  ctrlStrb_t strb;

  pwm_scaled_timer_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_ctrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  pwm_scaled_timer_dp #(
    .NUM_CH(NUM_CH), .CMP_W(CMP_W), .CNT_W(CNT_W), .SCALE_W(SCALE_W)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdData (rdData),
    .pwmOut (pwmOut)
  );

endmodule

// File: tb/test_pwm_scaled_timer.sv
module test_pwm_scaled_timer;

  localparam int NUM_CH = 4;
  localparam int CMP_W  = 4;
  localparam int CNT_W  = 19;
  localparam int ADDR_W = 4;
  localparam logic [31:0] RUN_C = 32'h0000_1000;
  localparam logic [31:0] RUN_1 = 32'h0000_2000;
  localparam logic [31:0] ZC    = 32'h0000_0200;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              rdEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wrData = '0;
  logic [31:0]       rdData;
  logic [NUM_CH-1:0] pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int lowCnt [NUM_CH];

  logic [31:0] expQ [$];
  string       tagQ [$];
  logic        rdFlag = 1'b0;

  always #10 clk = ~clk;

  pwm_scaled_timer #(.NUM_CH(NUM_CH), .CMP_W(CMP_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W))
    i_pwm_scaled_timer (
      .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
      .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: read data is valid one clock after rdEn
  always @(posedge clk) rdFlag <= rdEn;
  always @(negedge clk) begin
    if (rdFlag && expQ.size() > 0) chk(rdData, expQ.pop_front(), tagQ.pop_front());
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input int a, input logic [31:0] d);
    addr = ADDR_W'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input int a, input logic [31:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    addr = ADDR_W'(a); rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0; tick(3); rstN = 1'b1; tick(1);
  endtask

  task automatic countLow(input int cycles);
    for (int c = 0; c < NUM_CH; c++) lowCnt[c] = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      for (int c = 0; c < NUM_CH; c++) if (!pwmOut[c]) lowCnt[c]++;
    end
  endtask

  task automatic measPeriod(input int ch, output int per);
    logic prev;
    int t, first;
    prev = pwmOut[ch]; t = 0; first = -1; per = -1;
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      t++;
      if (prev && !pwmOut[ch]) begin
        if (first < 0) first = t;
        else begin per = t - first; break; end
      end
      prev = pwmOut[ch];
    end
  endtask

  initial begin : watchdog
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stimulus
    int per;
    doReset();

    // R1 reset state
    chk(32'(pwmOut), 32'hF, "R1 outputs high");
    chk(rdData, 32'h0, "R1 rdData");
    rdReg(0, 32'h0, "R1 cfg");
    rdReg(2, 32'h0, "R1 count");
    rdReg(8, 32'h0, "R1 cmp0");
    rdReg(11, 32'h0, "R1 cmp3");

    // R2 writable mask
    wrReg(0, 32'hFFFF_FFFF);
    rdReg(0, 32'h1101_370F, "R2 mask");
    wrReg(0, 32'h0);
    rdReg(0, 32'h0, "R2 clear");

    // R3 / R4 counting and scaled view
    doReset();
    tick(5);
    rdReg(2, 32'd0, "R3 idle holds");
    wrReg(0, RUN_C | 32'd2); tick(36); wrReg(0, 32'd2);
    rdReg(2, 32'd37, "R3 count");
    rdReg(4, 32'd9, "R4 scaled");
    tick(10);
    rdReg(2, 32'd37, "R3 stopped hold");
    wrReg(0, RUN_C | 32'd2); tick(32); wrReg(0, 32'd2);
    rdReg(2, 32'd70, "R3 count again");
    rdReg(4, 32'd1, "R4 truncated");
    wrReg(0, 32'd0);
    rdReg(4, 32'd6, "R4 scale0");
    wrReg(0, 32'd3);
    rdReg(4, 32'd8, "R4 scale3");

    // R11 read port
    rdReg(1, 32'h0, "R11 unmapped");
    rdReg(12, 32'h0, "R11 beyond channels");
    rdReg(2, 32'd70, "R11 count");
    tick(3);
    chk(rdData, 32'd70, "R11 hold");

    // R5 / R7 / R6 duty and period
    doReset();
    wrReg(8, 32'd5); wrReg(9, 32'd0); wrReg(10, 32'd15); wrReg(11, 32'd8);
    wrReg(0, RUN_C);
    tick(20);
    countLow(64);
    chk(32'(lowCnt[0]), 32'd20, "R5 ch0 duty");
    chk(32'(lowCnt[1]), 32'd0, "R5 ch1 zero cmp");
    chk(32'(lowCnt[2]), 32'd60, "R5 ch2 max cmp");
    chk(32'(lowCnt[3]), 32'd32, "R5 ch3 half");
    measPeriod(3, per);
    chk(32'(per), 32'd16, "R7 period scale0");
    wrReg(0, RUN_C | 32'd1);
    tick(40);
    measPeriod(3, per);
    chk(32'(per), 32'd32, "R7 period scale1");
    countLow(128);
    chk(32'(lowCnt[0]), 32'd40, "R5 ch0 scale1");
    chk(32'(lowCnt[3]), 32'd64, "R5 ch3 scale1");
    wrReg(0, 32'd1);
    chk(32'(pwmOut), 32'hF, "R6 stop high");
    countLow(20);
    chk(32'(lowCnt[0] + lowCnt[2] + lowCnt[3]), 32'd0, "R6 stays high");

    // R8 zero-compare
    wrReg(8, 32'd5); wrReg(9, 32'd2);
    wrReg(0, RUN_C | ZC);
    tick(40);
    measPeriod(1, per);
    chk(32'(per), 32'd6, "R8 period cmp0=5");
    countLow(60);
    chk(32'(lowCnt[1]), 32'd20, "R8 ch1 duty");
    wrReg(0, RUN_C | ZC | 32'd1);
    tick(40);
    measPeriod(1, per);
    chk(32'(per), 32'd12, "R8 period scale1");

    // R9 run-once
    doReset();
    wrReg(8, 32'd8);
    wrReg(0, RUN_1);
    chk(32'(pwmOut[0]), 32'd0, "R9 running low");
    tick(40);
    rdReg(0, 32'h0, "R9 once cleared");
    rdReg(2, 32'd16, "R9 stopped at period end");
    chk(32'(pwmOut), 32'hF, "R9 outputs high");

    // R10 immediate compare update
    doReset();
    wrReg(8, 32'd2);
    wrReg(0, RUN_C | 32'd3);
    tick(9);
    chk(32'(pwmOut[0]), 32'd0, "R10 before update");
    wrReg(8, 32'd1);
    chk(32'(pwmOut[0]), 32'd1, "R10 lowered cmp");
    wrReg(8, 32'd3);
    chk(32'(pwmOut[0]), 32'd0, "R10 raised cmp");

    tick(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule